// File: doc/BRIEF.md
# Display core clock change sequencer

This block moves the display core clock from its present frequency to a new one. A request names either a target frequency in MHz directly, or the largest pixel clock (in kHz) that the active displays need, in which case a front-end picks the smallest supported frequency bin with enough headroom. The sequencer then runs a fixed programming order. It announces the change to the power controller through a request/acknowledge mailbox. It relocks the clock PLL only when the move requires it. It programs the PLL ratio, the PLL enable and the clock control word through a single-outstanding register-bus master. Last, it reports the new operating point to the power controller.

Software or a higher-level mode-set engine pulses `start` and waits for `done`. The flags `err_invalid` and `err_mbox` describe the request that just finished. `err_timeout` is sticky: it records that some PLL wait ran out its cycle budget and the sequence carried on anyway. The committed frequency is kept inside the block. A request that resolves to the frequency already committed finishes without touching the bus or the mailbox.

Top module: `dclk_change_seq`

## Requirements
- R1: In pixel mode the bin is chosen from `req_pix_khz`. A value above 624000 is invalid. A value above 518400 gives 624 MHz, above 345600 gives 576, above 259200 gives 384, above 129600 gives 288, and anything else gives 144.
- R2: In direct mode only 0 (off), 144, 288, 384, 576 and 624 MHz are accepted. Any invalid request ends with `err_invalid` set, no bus or mailbox traffic, and the committed frequency unchanged.
- R3: The divider code sits at bits 23:22 of the clock control word (register 2). It is 3 for 144 MHz, 2 for 288, 1 for 384 and 0 for 576 and 624.
- R4: The PLL ratio register (register 1) is written with 0x3C for every nonzero target except 624 MHz, which gets 0x41.
- R5: The control word is read, then written back. Bits 10:0 hold (target MHz − 1) × 2 and bit 16 (precharge) is set only for targets of 500 MHz or more. All other bits keep their read value.
- R6: Before any register access the mailbox is sent 0x80000000. If that transaction reports failure, `err_mbox` is set, no register is accessed, and the committed frequency stays.
- R7: The PLL is disabled (register 0 written with bit 31 clear), and the block polls until lock bit 30 reads clear, only when the target is 0, the committed frequency is 624 MHz, or the target is 624 MHz.
- R8: For a nonzero target, the ratio is written, then register 0 is written with enable bit 31 set, then register 0 is polled until bit 30 reads set. Only after this does the control word access happen.
- R9: At the end the mailbox is sent ceil(target/25) for a nonzero target, or 1 for off. A failure here sets `err_mbox` and the committed frequency is not updated.
- R10: Each poll is bounded by `TMO_CYC` cycles. On expiry `err_timeout` is set, stays set until reset, and the sequence continues with the next step.
- R11: A valid request equal to the committed frequency finishes with no bus or mailbox traffic.
- R12: `busy` is high from the cycle after `start` until `done`. `done` is a one-cycle pulse with `busy` low. A bus request is held, with stable address and data, until acknowledged.
- R13: The committed frequency (`cur_mhz`, 0 after reset) changes only in the `done` cycle of a fully successful sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a clock change (sampled while idle) |
| req_direct | input | 1 | 1: use `req_mhz`; 0: pick a bin from `req_pix_khz` |
| req_mhz | input | 10 | Direct target frequency in MHz |
| req_pix_khz | input | PIX_W | Maximum pixel clock in kHz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_invalid | output | 1 | Last request was rejected |
| err_mbox | output | 1 | Last request saw a mailbox failure |
| err_timeout | output | 1 | Sticky: a PLL poll ran out of time |
| cur_mhz | output | 10 | Committed core clock frequency |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 2 | 0 PLL control, 1 PLL ratio, 2 clock control |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| mb_req | output | 1 | Mailbox message request |
| mb_data | output | DATA_W | Mailbox message value |
| mb_ack | input | 1 | Mailbox transaction complete |
| mb_fail | input | 1 | Mailbox transaction failed, valid with `mb_ack` |

## Verification
The bench aims at the relock decision, where a design that tests only the target against 624 MHz, and ignores the committed frequency, would skip the PLL disable when leaving 624 MHz. It also crosses the bin thresholds exactly: a compare of `>=` in place of `>` sends a 129600 kHz request to 288 MHz. The read-modify-write of the control word is checked against a word with mixed background bits, so a design that clears unrelated bits, or leaves a stale divider or precharge bit, shows a wrong word. The failure and stall cases check the behaviour a wrong design would get backwards: after a failed pre-notification no register may be touched, while a PLL that never locks must raise the sticky timeout flag and still finish.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

  localparam int unsigned MHZ_W   = 10;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned FREQ_W  = 11;
  localparam int unsigned DIV_W   = 2;

  localparam logic [ADDR_W-1:0] REG_PLL   = 2'd0;
  localparam logic [ADDR_W-1:0] REG_RATIO = 2'd1;
  localparam logic [ADDR_W-1:0] REG_CTL   = 2'd2;

  localparam int unsigned PLL_EN_BIT   = 31;
  localparam int unsigned PLL_LOCK_BIT = 30;
  localparam int unsigned DIV_LSB      = 22;
  localparam int unsigned PRECH_BIT    = 16;
  localparam int unsigned PRECH_MIN    = 500;

  localparam logic [MHZ_W-1:0] F_OFF = 10'd0;
  localparam logic [MHZ_W-1:0] F_144 = 10'd144;
  localparam logic [MHZ_W-1:0] F_288 = 10'd288;
  localparam logic [MHZ_W-1:0] F_384 = 10'd384;
  localparam logic [MHZ_W-1:0] F_576 = 10'd576;
  localparam logic [MHZ_W-1:0] F_624 = 10'd624;

  typedef enum logic [3:0] {
    S_IDLE, S_EVAL, S_MB_PRE, S_PLL_OFF, S_WAIT_UNLK, S_RATIO,
    S_PLL_ON, S_WAIT_LOCK, S_CTL_RD, S_CTL_WR, S_MB_POST, S_FINISH
  } seq_state_e;

  function automatic logic mhz_supported(input logic [MHZ_W-1:0] m);
    return (m == F_OFF) || (m == F_144) || (m == F_288) ||
           (m == F_384) || (m == F_576) || (m == F_624);
  endfunction

endpackage

// File: rtl/dclk_bin_pick.sv
module dclk_bin_pick import dclk_pkg::*; #(
  parameter int unsigned PIX_W = 20
) (
  input  logic [PIX_W-1:0] pix_khz,
  output logic [MHZ_W-1:0] bin_mhz,
  output logic             bin_bad
);
  // Headroom rule: a bin is left once the load exceeds 90 % of it.
  localparam int unsigned MAX_KHZ = 624000;
  localparam int unsigned TH_624  = 576000 * 9 / 10;
  localparam int unsigned TH_576  = 384000 * 9 / 10;
  localparam int unsigned TH_384  = 288000 * 9 / 10;
  localparam int unsigned TH_288  = 144000 * 9 / 10;

  logic [31:0] pix32;
  assign pix32 = 32'(pix_khz);

  always_comb begin
    bin_bad = 1'b0;
    if (pix32 > MAX_KHZ) begin
      bin_bad = 1'b1;
      bin_mhz = F_OFF;
    end else if (pix32 > TH_624) bin_mhz = F_624;
    else if (pix32 > TH_576)     bin_mhz = F_576;
    else if (pix32 > TH_384)     bin_mhz = F_384;
    else if (pix32 > TH_288)     bin_mhz = F_288;
    else                         bin_mhz = F_144;
  end
endmodule

// File: rtl/dclk_bin_decode.sv
module dclk_bin_decode import dclk_pkg::*; #(
  parameter int unsigned   DATA_W     = 32,
  parameter int unsigned   RATIO_W    = 7,
  parameter logic [RATIO_W-1:0] RATIO_BASE = 7'h3C,
  parameter logic [RATIO_W-1:0] RATIO_TOP  = 7'h41
) (
  input  logic [MHZ_W-1:0]   mhz,
  output logic [DIV_W-1:0]   div_code,
  output logic [RATIO_W-1:0] ratio,
  output logic [FREQ_W-1:0]  freq_field,
  output logic               prech,
  output logic [DATA_W-1:0]  post_msg
);
  localparam logic [MHZ_W-1:0] STEP_MHZ = 10'd25;

  always_comb begin
    unique case (mhz)
      F_144:   div_code = 2'd3;
      F_288:   div_code = 2'd2;
      F_384:   div_code = 2'd1;
      default: div_code = 2'd0;
    endcase
  end

  assign ratio      = (mhz == F_624) ? RATIO_TOP : RATIO_BASE;
  assign freq_field = {mhz - 10'd1, 1'b0};
  assign prech      = (32'(mhz) >= PRECH_MIN);
  assign post_msg   = (mhz == F_OFF) ? DATA_W'(1)
                    : DATA_W'((mhz + (STEP_MHZ - 10'd1)) / STEP_MHZ);
endmodule

// File: rtl/dclk_wait_timer.sv
module dclk_wait_timer #(
  parameter int unsigned TMO_CYC = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/dclk_change_seq.sv
module dclk_change_seq import dclk_pkg::*; #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PIX_W   = 20,
  parameter int unsigned TMO_CYC = 125000,
  parameter int unsigned RATIO_W = 7,
  parameter logic [RATIO_W-1:0] RATIO_BASE = 7'h3C,
  parameter logic [RATIO_W-1:0] RATIO_TOP  = 7'h41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              req_direct,
  input  logic [MHZ_W-1:0]  req_mhz,
  input  logic [PIX_W-1:0]  req_pix_khz,
  output logic              busy,
  output logic              done,
  output logic              err_invalid,
  output logic              err_mbox,
  output logic              err_timeout,
  output logic [MHZ_W-1:0]  cur_mhz,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              mb_req,
  output logic [DATA_W-1:0] mb_data,
  input  logic              mb_ack,
  input  logic              mb_fail
);
  localparam logic [DATA_W-1:0] PRE_MSG = DATA_W'(1) << PLL_EN_BIT;
  localparam logic [DATA_W-1:0] EN_WORD = DATA_W'(1) << PLL_EN_BIT;
  localparam logic [DATA_W-1:0] CTL_MASK =
      (DATA_W'(3) << DIV_LSB) | (DATA_W'(1) << PRECH_BIT) | DATA_W'((1 << FREQ_W) - 1);

  seq_state_e        state;
  logic              req_direct_q;
  logic [MHZ_W-1:0]  req_mhz_q;
  logic [PIX_W-1:0]  req_pix_q;
  logic [MHZ_W-1:0]  tgt_q;
  logic [MHZ_W-1:0]  cur_q;
  logic [DATA_W-1:0] ctl_q;
  logic              commit_q;

  logic [MHZ_W-1:0]   pick_mhz, sel_mhz;
  logic               pick_bad, sel_bad;
  logic [DIV_W-1:0]   dec_div;
  logic [RATIO_W-1:0] dec_ratio;
  logic [FREQ_W-1:0]  dec_freq;
  logic               dec_prech;
  logic [DATA_W-1:0]  dec_post;
  logic               tmo, wait_run, need_off;
  logic [DATA_W-1:0]  ctl_new;

  dclk_bin_pick #(.PIX_W(PIX_W)) u_pick (
    .pix_khz (req_pix_q),
    .bin_mhz (pick_mhz),
    .bin_bad (pick_bad)
  );

  dclk_bin_decode #(
    .DATA_W(DATA_W), .RATIO_W(RATIO_W),
    .RATIO_BASE(RATIO_BASE), .RATIO_TOP(RATIO_TOP)
  ) u_dec (
    .mhz        (tgt_q),
    .div_code   (dec_div),
    .ratio      (dec_ratio),
    .freq_field (dec_freq),
    .prech      (dec_prech),
    .post_msg   (dec_post)
  );

  assign wait_run = (state == S_WAIT_UNLK) || (state == S_WAIT_LOCK);

  dclk_wait_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (wait_run),
    .expired (tmo)
  );

  assign sel_mhz  = req_direct_q ? req_mhz_q : pick_mhz;
  assign sel_bad  = req_direct_q ? !mhz_supported(req_mhz_q) : pick_bad;
  assign need_off = (tgt_q == F_OFF) || (tgt_q == F_624) || (cur_q == F_624);
  assign ctl_new  = (ctl_q & ~CTL_MASK)
                  | (DATA_W'(dec_div) << DIV_LSB)
                  | (DATA_W'(dec_prech) << PRECH_BIT)
                  | DATA_W'(dec_freq);
  assign cur_mhz  = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      req_direct_q <= 1'b0;
      req_mhz_q    <= '0;
      req_pix_q    <= '0;
      tgt_q        <= '0;
      cur_q        <= F_OFF;
      ctl_q        <= '0;
      commit_q     <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      err_invalid  <= 1'b0;
      err_mbox     <= 1'b0;
      err_timeout  <= 1'b0;
      bus_req      <= 1'b0;
      bus_we       <= 1'b0;
      bus_addr     <= '0;
      bus_wdata    <= '0;
      mb_req       <= 1'b0;
      mb_data      <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          req_direct_q <= req_direct;
          req_mhz_q    <= req_mhz;
          req_pix_q    <= req_pix_khz;
          busy         <= 1'b1;
          err_invalid  <= 1'b0;
          err_mbox     <= 1'b0;
          state        <= S_EVAL;
        end
        S_EVAL: begin
          if (sel_bad) begin
            err_invalid <= 1'b1;
            state       <= S_FINISH;
          end else if (sel_mhz == cur_q) begin
            state <= S_FINISH;
          end else begin
            tgt_q <= sel_mhz;
            state <= S_MB_PRE;
          end
        end
        S_MB_PRE: begin
          if (!mb_req) begin
            mb_req  <= 1'b1;
            mb_data <= PRE_MSG;
          end else if (mb_ack) begin
            mb_req <= 1'b0;
            if (mb_fail) begin
              err_mbox <= 1'b1;
              state    <= S_FINISH;
            end else begin
              state <= need_off ? S_PLL_OFF : S_RATIO;
            end
          end
        end
        S_PLL_OFF: begin
          if (!bus_req) begin
            bus_req   <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= REG_PLL;
            bus_wdata <= '0;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            state   <= S_WAIT_UNLK;
          end
        end
        S_WAIT_UNLK: begin
          if (!bus_req) begin
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= REG_PLL;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            if (!bus_rdata[PLL_LOCK_BIT] || tmo) begin
              if (bus_rdata[PLL_LOCK_BIT]) err_timeout <= 1'b1;
              state <= (tgt_q == F_OFF) ? S_MB_POST : S_RATIO;
            end
          end
        end
        S_RATIO: begin
          if (!bus_req) begin
            bus_req   <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= REG_RATIO;
            bus_wdata <= DATA_W'(dec_ratio);
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            state   <= S_PLL_ON;
          end
        end
        S_PLL_ON: begin
          if (!bus_req) begin
            bus_req   <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= REG_PLL;
            bus_wdata <= EN_WORD;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            state   <= S_WAIT_LOCK;
          end
        end
        S_WAIT_LOCK: begin
          if (!bus_req) begin
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= REG_PLL;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            if (bus_rdata[PLL_LOCK_BIT] || tmo) begin
              if (!bus_rdata[PLL_LOCK_BIT]) err_timeout <= 1'b1;
              state <= S_CTL_RD;
            end
          end
        end
        S_CTL_RD: begin
          if (!bus_req) begin
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= REG_CTL;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            ctl_q   <= bus_rdata;
            state   <= S_CTL_WR;
          end
        end
        S_CTL_WR: begin
          if (!bus_req) begin
            bus_req   <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= REG_CTL;
            bus_wdata <= ctl_new;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            state   <= S_MB_POST;
          end
        end
        S_MB_POST: begin
          if (!mb_req) begin
            mb_req  <= 1'b1;
            mb_data <= dec_post;
          end else if (mb_ack) begin
            mb_req <= 1'b0;
            if (mb_fail) err_mbox <= 1'b1;
            else         commit_q <= 1'b1;
            state <= S_FINISH;
          end
        end
        S_FINISH: begin
          if (commit_q) cur_q <= tgt_q;
          commit_q <= 1'b0;
          busy     <= 1'b0;
          done     <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dclk_change_seq_chk.sv
module dclk_change_seq_chk import dclk_pkg::*; #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              err_invalid,
  input logic              err_timeout,
  input logic [MHZ_W-1:0]  cur_mhz,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic              mb_req
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r12_bus_in_seq: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

  a_r12_mb_in_seq: assert property (@(posedge clk) disable iff (rst)
    mb_req |-> busy);

  a_r12_bus_hold: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r12_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r10_timeout_sticky: assert property (@(posedge clk) disable iff (rst)
    err_timeout |=> err_timeout);

  a_r13_commit_at_done: assert property (@(posedge clk) disable iff (rst)
    (past_ok && (cur_mhz != $past(cur_mhz))) |-> done);

  a_r2_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
    err_invalid |-> (!bus_req && !mb_req));

  a_r4_ratio_code: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && (bus_addr == REG_RATIO)) |->
      ((bus_wdata == DATA_W'(7'h3C)) || (bus_wdata == DATA_W'(7'h41))));
endmodule

bind dclk_change_seq dclk_change_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .done        (done),
  .err_invalid (err_invalid),
  .err_timeout (err_timeout),
  .cur_mhz     (cur_mhz),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_ack     (bus_ack),
  .mb_req      (mb_req)
);

// File: tb/dclk_change_seq_bench.sv
`timescale 1ns/1ps
module dclk_change_seq_bench;
  localparam int PIX_W = 20;
  localparam int TMO   = 64;
  localparam logic [31:0] CTL_INIT = 32'hA5A5_A5A5;
  localparam logic [31:0] MASK = (32'd3 << 22) | (32'd1 << 16) | 32'h7FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, req_direct = 1'b0;
  logic [9:0] req_mhz = '0;
  logic [PIX_W-1:0] req_pix = '0;
  logic busy, done, err_invalid, err_mbox, err_timeout;
  logic [9:0] cur_mhz;
  logic bus_req, bus_we, bus_ack;
  logic [1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, mb_data;
  logic mb_req, mb_ack, mb_fail;

  always #4 clk = ~clk;

  dclk_change_seq #(.PIX_W(PIX_W), .TMO_CYC(TMO)) u_dclk_change_seq (
    .clk(clk), .rst(rst), .start(start), .req_direct(req_direct),
    .req_mhz(req_mhz), .req_pix_khz(req_pix), .busy(busy), .done(done),
    .err_invalid(err_invalid), .err_mbox(err_mbox), .err_timeout(err_timeout),
    .cur_mhz(cur_mhz), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .mb_req(mb_req), .mb_data(mb_data), .mb_ack(mb_ack), .mb_fail(mb_fail)
  );

  // Register and mailbox model
  logic [31:0] m_pll, m_ratio, m_ctl;
  int lock_cnt, lock_mode;
  bit fail_pre, clr_stats;
  int n_off, n_on, n_ratio, n_ctl, n_rd, n_mb, order_bad;
  logic [31:0] mb_first, mb_last;
  logic lock_now;

  assign lock_now = (lock_mode == 1) ? 1'b0 : (lock_mode == 2) ? 1'b1
                  : (m_pll[31] && lock_cnt >= 3);

  always @(posedge clk) begin
    if (rst) begin
      m_pll = '0; m_ratio = '0; m_ctl = CTL_INIT; lock_cnt = 0;
      bus_ack <= 1'b0; bus_rdata <= '0; mb_ack <= 1'b0; mb_fail <= 1'b0;
      n_off = 0; n_on = 0; n_ratio = 0; n_ctl = 0; n_rd = 0; n_mb = 0; order_bad = 0;
      mb_first = '0; mb_last = '0;
    end else begin
      bus_ack <= 1'b0;
      mb_ack  <= 1'b0;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        if (bus_we) begin
          case (bus_addr)
            2'd0: begin
              m_pll = bus_wdata;
              if (bus_wdata[31]) begin
                n_on++;
                if (n_ratio == 0) order_bad++;
              end else n_off++;
            end
            2'd1: begin m_ratio = bus_wdata; n_ratio++; end
            default: begin
              m_ctl = bus_wdata; n_ctl++;
              if (n_on == 0) order_bad++;
            end
          endcase
        end else begin
          n_rd++;
          bus_rdata <= (bus_addr == 2'd0) ? {m_pll[31], lock_now, m_pll[29:0]}
                     : (bus_addr == 2'd1) ? m_ratio : m_ctl;
        end
      end
      if (mb_req && !mb_ack) begin
        mb_ack  <= 1'b1;
        mb_fail <= fail_pre && (mb_data == 32'h8000_0000);
        if (n_mb == 0) mb_first = mb_data;
        mb_last = mb_data;
        n_mb++;
      end
      if (m_pll[31]) begin if (lock_cnt < 3) lock_cnt++; end
      else lock_cnt = 0;
      if (clr_stats) begin
        n_off = 0; n_on = 0; n_ratio = 0; n_ctl = 0; n_rd = 0; n_mb = 0; order_bad = 0;
        mb_first = '0; mb_last = '0;
      end
    end
  end

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what,
                    input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, what, act, exp);
  endtask

  task automatic run_op(input bit direct, input int mhz, input int pix);
    int w;
    @(negedge clk); clr_stats = 1'b1;
    @(negedge clk); clr_stats = 1'b0;
    req_direct = direct; req_mhz = 10'(mhz); req_pix = PIX_W'(pix); start = 1'b1;
    @(negedge clk); start = 1'b0;
    eq("R12", "busy after start", 32'(busy), 32'd1);
    w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    eq("R12", "done reached", 32'(done), 32'd1);
    eq("R12", "busy low at done", 32'(busy), 32'd0);
  endtask

  function automatic logic [31:0] div_of(input int m);
    case (m)
      144: return 32'd3;
      288: return 32'd2;
      384: return 32'd1;
      default: return 32'd0;
    endcase
  endfunction

  // Full nonzero change and its expected programming
  task automatic change(input string tag, input bit direct, input int mhz,
                        input int pix, input int exp_off);
    logic [31:0] pre, exp_ctl;
    pre = m_ctl;
    run_op(direct, mhz, pix);
    exp_ctl = (pre & ~MASK) | (div_of(mhz) << 22)
            | ((mhz >= 500) ? (32'd1 << 16) : 32'd0) | 32'((mhz - 1) * 2);
    eq("R3/R5", {tag, " control word"}, m_ctl, exp_ctl);
    eq("R4", {tag, " ratio"}, m_ratio, (mhz == 624) ? 32'h41 : 32'h3C);
    eq("R7", {tag, " PLL disables"}, 32'(n_off), 32'(exp_off));
    eq("R8", {tag, " order ratio/enable/control"}, 32'(order_bad), 32'd0);
    eq("R6", {tag, " pre message"}, mb_first, 32'h8000_0000);
    eq("R9", {tag, " post message"}, mb_last, 32'((mhz + 24) / 25));
    eq("R13", {tag, " committed freq"}, 32'(cur_mhz), 32'(mhz));
    eq("R2", {tag, " no invalid flag"}, 32'(err_invalid), 32'd0);
  endtask

  task automatic t_reset;
    eq("R13", "reset cur_mhz", 32'(cur_mhz), 32'd0);
    eq("R12", "reset busy", 32'(busy), 32'd0);
    eq("R12", "reset bus_req", 32'(bus_req), 32'd0);
    eq("R10", "reset err_timeout", 32'(err_timeout), 32'd0);
  endtask

  task automatic t_quiet(input string req, input string tag, input int exp_cur);
    eq(req, {tag, " bus traffic"}, 32'(n_off + n_on + n_ratio + n_ctl + n_rd), 32'd0);
    eq(req, {tag, " mailbox traffic"}, 32'(n_mb), 32'd0);
    eq(req, {tag, " cur unchanged"}, 32'(cur_mhz), 32'(exp_cur));
  endtask

  task automatic t_invalid;
    run_op(1'b0, 0, 700000);
    eq("R1", "pixel above 624000 invalid", 32'(err_invalid), 32'd1);
    t_quiet("R2", "invalid pixel", 384);
    run_op(1'b1, 300, 0);
    eq("R2", "direct 300 invalid", 32'(err_invalid), 32'd1);
    t_quiet("R2", "invalid direct", 384);
  endtask

  task automatic t_skip;
    run_op(1'b0, 0, 300000);
    eq("R11", "skip no error", 32'(err_invalid | err_mbox), 32'd0);
    t_quiet("R11", "same bin", 384);
  endtask

  task automatic t_pre_fail;
    fail_pre = 1'b1;
    run_op(1'b1, 288, 0);
    fail_pre = 1'b0;
    eq("R6", "pre fail flag", 32'(err_mbox), 32'd1);
    eq("R6", "pre fail no bus", 32'(n_off + n_on + n_ratio + n_ctl + n_rd), 32'd0);
    eq("R6", "pre fail single message", 32'(n_mb), 32'd1);
    eq("R13", "pre fail cur kept", 32'(cur_mhz), 32'd384);
  endtask

  task automatic t_bounds;
    run_op(1'b0, 0, 129600);
    eq("R1", "129600 kHz -> 144", 32'(cur_mhz), 32'd144);
    change("R1 129601", 1'b0, 288, 129601, 0);
    run_op(1'b0, 0, 259200);
    eq("R1", "259200 kHz stays 288", 32'(cur_mhz), 32'd288);
    eq("R11", "259200 kHz no traffic", 32'(n_mb), 32'd0);
  endtask

  task automatic t_timeout;
    lock_mode = 1;
    run_op(1'b1, 576, 0);
    lock_mode = 0;
    eq("R10", "lock timeout flag", 32'(err_timeout), 32'd1);
    eq("R10", "control still written", 32'(n_ctl), 32'd1);
    eq("R10", "post still sent", mb_last, 32'd24);
    eq("R10", "cur after timeout", 32'(cur_mhz), 32'd576);
  endtask

  task automatic t_off;
    run_op(1'b1, 0, 0);
    eq("R7", "off disables PLL", 32'(n_off), 32'd1);
    eq("R8", "off writes no ratio/enable/control", 32'(n_ratio + n_on + n_ctl), 32'd0);
    eq("R9", "off post message", mb_last, 32'd1);
    eq("R13", "off committed", 32'(cur_mhz), 32'd0);
    eq("R10", "timeout still sticky", 32'(err_timeout), 32'd1);
  endtask

  initial begin
    lock_mode = 0; fail_pre = 1'b0; clr_stats = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    change("144 from off", 1'b1, 144, 0, 0);
    change("to 624", 1'b1, 624, 0, 1);
    change("624 to 576", 1'b1, 576, 0, 1);
    change("pixel 300000", 1'b0, 384, 300000, 0);
    t_skip();
    t_invalid();
    t_pre_fail();
    t_bounds();
    t_timeout();
    t_off();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule